// File: doc/BRIEF.md
# I/Q Input Port Demultiplexer

This block is the capture stage in front of a two-channel converter datapath. It takes input words on two parallel ports and delivers an aligned in-phase/quadrature sample pair, in two's complement, with a valid strobe. In two-port operation, port A carries the in-phase stream and port B the quadrature stream. Both are captured on the same clock edge, so a new pair comes out on every cycle.

In one-port operation, in-phase and quadrature words share port A. A channel-select input tags each word. The block holds the word that leads each pair until its partner arrives, then presents both halves together. Four static configuration inputs set the behaviour. One picks between the two port modes. One inverts the meaning of the select. One decides whether a pair opens with the in-phase word or with the quadrature word. One marks the input as straight binary, which the block converts to two's complement by flipping the top bit. A word that repeats the channel of the word before it breaks the alternation. The block discards the affected partial pair and raises a sticky error flag.

Top module: `iq_port_demux`

## Requirements
- R1: While reset is asserted, and after it, until the first completed sample, `out_valid`, `out_i`, `out_q` and `err_sticky` are all 0.
- R2: With `cfg_one_port`=0, the clock edge that samples `in_a` and `in_b` presents them (after format conversion) on `out_i` and `out_q` respectively, with `out_valid`=1, on every cycle.
- R3: With `cfg_offset_binary`=1, bit 11 of each output word is the inverse of bit 11 of the input word, and bits 10..0 pass unchanged. With 0, words pass unchanged. This holds in both port modes.
- R4: With `cfg_one_port`=1, a word on `in_a` belongs to the quadrature channel when `in_sel` XOR `cfg_sel_invert` is 1, and to the in-phase channel when it is 0.
- R5: With `cfg_qi_order`=0, an in-phase word opens a pair and the next quadrature word completes it. With 1, a quadrature word opens it and the next in-phase word completes it.
- R6: In one-port mode, `out_valid` is 1 only on the cycle after the edge that captures a completing word, with both halves on the outputs at once. The edge that captures an opening word leaves `out_valid` at 0.
- R7: In one-port mode, an opening word that arrives while another opening word is held replaces the held word and sets `err_sticky` at that edge. A completing word that directly follows a completed or dropped completing word is dropped and also sets `err_sticky`.
- R8: `err_sticky` stays at 1 until reset, regardless of later correct traffic.
- R9: On entry to one-port mode, a completing word that arrives before any opening word is dropped without output and without setting `err_sticky`.
- R10: Leaving one-port mode discards any held word. On return, the first completing word is treated as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_one_port | input | 1 | 1 = interleaved words on port A, 0 = separate ports |
| cfg_sel_invert | input | 1 | Inverts the meaning of `in_sel` |
| cfg_qi_order | input | 1 | 1 = pairs open with the quadrature word |
| cfg_offset_binary | input | 1 | 1 = inputs are straight binary |
| in_a | input | 12 | Port A word (in-phase, or interleaved stream) |
| in_b | input | 12 | Port B word (quadrature in two-port mode) |
| in_sel | input | 1 | Channel tag of the port A word in one-port mode |
| out_i | output | 12 | In-phase output, two's complement |
| out_q | output | 12 | Quadrature output, two's complement |
| out_valid | output | 1 | Output pair is new on this cycle |
| err_sticky | output | 1 | Interleave sequence error seen since reset |

## Verification
The assertions watch four things on every cycle:
- valid stays high in two-port mode;
- the top bit of each output tracks the format setting;
- no two adjacent cycles both complete a pair;
- the error flag latches and stays set, and leaving one-port mode clears the held state.

Only the bench scenarios can show the rest:
- which halves pair up under each select polarity and ordering;
- that a stale opening word is replaced rather than kept;
- that a stray completing word after mode entry is dropped silently.

// File: rtl/iq_demux_pkg.sv
package iq_demux_pkg;

   typedef enum logic {
      CH_I = 1'b0,
      CH_Q = 1'b1
   } chan_e;

   localparam int unsigned DEF_WORD_W = 12;

endpackage

// File: rtl/iq_word_fmt.sv
module iq_word_fmt #(
   parameter int unsigned WORD_W = 12,
   parameter int unsigned LANES  = 2,
   localparam int unsigned BUS_W = WORD_W * LANES
) (
   input  logic             offset_bin,
   input  logic [BUS_W-1:0] din,
   output logic [BUS_W-1:0] dout
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("iq_word_fmt: WORD_W must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("iq_word_fmt: LANES must be at least 1");
      end
   endgenerate

   genvar ln;
   generate
      for (ln = 0; ln < LANES; ln++) begin : g_lane
         localparam int unsigned LO  = ln * WORD_W;
         localparam int unsigned TOP = LO + WORD_W - 1;
         assign dout[TOP]      = din[TOP] ^ offset_bin;
         assign dout[TOP-1:LO] = din[TOP-1:LO];
      end
   endgenerate

endmodule

// File: rtl/iq_interleave_asm.sv
module iq_interleave_asm
   import iq_demux_pkg::*;
#(
   parameter int unsigned WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sel_invert,
   input  logic              qi_order,
   input  logic [WORD_W-1:0] word,
   input  logic              sel,
   output logic              pair_done,
   output logic              seq_err,
   output logic [WORD_W-1:0] pair_i,
   output logic [WORD_W-1:0] pair_q
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("iq_interleave_asm: WORD_W must be at least 2");
      end
   endgenerate

   chan_e             word_ch;
   chan_e             open_ch;
   logic              is_open;
   logic              holding;
   logic              seen;
   logic [WORD_W-1:0] held_word;

   assign word_ch = chan_e'(sel ^ sel_invert);
   assign open_ch = qi_order ? CH_Q : CH_I;
   assign is_open = (word_ch == open_ch);

   assign pair_done = en && holding && !is_open;
   assign seq_err   = en && ((holding && is_open) || (!holding && !is_open && seen));

   assign pair_i = qi_order ? word : held_word;
   assign pair_q = qi_order ? held_word : word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         holding   <= 1'b0;
         seen      <= 1'b0;
         held_word <= '0;
      end else if (!en) begin
         holding <= 1'b0;
         seen    <= 1'b0;
      end else begin
         seen <= 1'b1;
         if (is_open) begin
            holding   <= 1'b1;
            held_word <= word;
         end else begin
            holding <= 1'b0;
         end
      end
   end

   AST_NO_BACK_TO_BACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      pair_done |=> !pair_done);   // R6
   AST_EXIT_DROPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!holding && !seen));   // R10

endmodule

// File: rtl/iq_port_demux.sv
module iq_port_demux
   import iq_demux_pkg::*;
#(
   parameter int unsigned WORD_W = DEF_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_one_port,
   input  logic              cfg_sel_invert,
   input  logic              cfg_qi_order,
   input  logic              cfg_offset_binary,
   input  logic [WORD_W-1:0] in_a,
   input  logic [WORD_W-1:0] in_b,
   input  logic              in_sel,
   output logic [WORD_W-1:0] out_i,
   output logic [WORD_W-1:0] out_q,
   output logic              out_valid,
   output logic              err_sticky
);

   localparam int unsigned PAIR_W = 2 * WORD_W;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("iq_port_demux: WORD_W must be at least 2");
      end
   endgenerate

   logic              pair_done;
   logic              seq_err;
   logic [WORD_W-1:0] pair_i;
   logic [WORD_W-1:0] pair_q;
   logic [PAIR_W-1:0] raw_pair;
   logic [PAIR_W-1:0] fmt_pair;

   iq_interleave_asm #(.WORD_W(WORD_W)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cfg_one_port),
      .sel_invert (cfg_sel_invert),
      .qi_order   (cfg_qi_order),
      .word       (in_a),
      .sel        (in_sel),
      .pair_done  (pair_done),
      .seq_err    (seq_err),
      .pair_i     (pair_i),
      .pair_q     (pair_q)
   );

   assign raw_pair = cfg_one_port ? {pair_q, pair_i} : {in_b, in_a};

   iq_word_fmt #(.WORD_W(WORD_W), .LANES(2)) u_fmt (
      .offset_bin (cfg_offset_binary),
      .din        (raw_pair),
      .dout       (fmt_pair)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_i      <= '0;
         out_q      <= '0;
         out_valid  <= 1'b0;
         err_sticky <= 1'b0;
      end else begin
         err_sticky <= err_sticky | seq_err;
         if (cfg_one_port) begin
            out_valid <= pair_done;
            if (pair_done) begin
               out_i <= fmt_pair[WORD_W-1:0];
               out_q <= fmt_pair[PAIR_W-1:WORD_W];
            end
         end else begin
            out_valid <= 1'b1;
            out_i     <= fmt_pair[WORD_W-1:0];
            out_q     <= fmt_pair[PAIR_W-1:WORD_W];
         end
      end
   end

   AST_TWO_PORT_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_one_port |=> out_valid);   // R2
   AST_MSB_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_one_port |=> (out_i[WORD_W-1] == $past(in_a[WORD_W-1] ^ cfg_offset_binary)));   // R3
   AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> err_sticky);   // R7
   AST_ERR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);   // R8

endmodule

// File: tb/sim_iq_port_demux.sv
`timescale 1ns/1ps
module sim_iq_port_demux;

   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_one_port = 1'b0;
   logic         cfg_sel_invert = 1'b0;
   logic         cfg_qi_order = 1'b0;
   logic         cfg_offset_binary = 1'b0;
   logic [W-1:0] in_a = '0;
   logic [W-1:0] in_b = '0;
   logic         in_sel = 1'b0;
   logic [W-1:0] out_i;
   logic [W-1:0] out_q;
   logic         out_valid;
   logic         err_sticky;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   iq_port_demux #(.WORD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_one_port(cfg_one_port), .cfg_sel_invert(cfg_sel_invert),
      .cfg_qi_order(cfg_qi_order), .cfg_offset_binary(cfg_offset_binary),
      .in_a(in_a), .in_b(in_b), .in_sel(in_sel),
      .out_i(out_i), .out_q(out_q), .out_valid(out_valid), .err_sticky(err_sticky)
   );

   // vector fields: {fmt, a, b, exp_i, exp_q}
   localparam logic [48:0] VEC [6] = '{
      {1'b0, 12'h123, 12'h456, 12'h123, 12'h456},
      {1'b1, 12'h800, 12'h000, 12'h000, 12'h800},
      {1'b1, 12'hFFF, 12'h7FF, 12'h7FF, 12'hFFF},
      {1'b0, 12'h800, 12'h7FF, 12'h800, 12'h7FF},
      {1'b1, 12'h0AB, 12'hF0F, 12'h8AB, 12'h70F},
      {1'b0, 12'h000, 12'hFFF, 12'h000, 12'hFFF}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic sel);
      in_a = a;
      in_b = b;
      in_sel = sel;
      @(posedge clk);
      #1;
   endtask

   task automatic check_pair(input string req, input logic [W-1:0] ei, input logic [W-1:0] eq);
      check(out_valid && out_i == ei && out_q == eq, req,
            {7'd0, out_valid, out_i, out_q}, {7'd0, 1'b1, ei, eq});
   endtask

   task automatic check_idle(input string req, input logic exp_err);
      check(!out_valid && err_sticky == exp_err, req,
            {30'd0, out_valid, err_sticky}, {30'd0, 1'b0, exp_err});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check(!out_valid && out_i == 0 && out_q == 0 && !err_sticky, "R1",
            {7'd0, out_valid, out_i, out_q} | {31'd0, err_sticky}, 32'd0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 5000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      do_reset();

      // R2, R3: two-port vectors
      for (int v = 0; v < 6; v++) begin
         cfg_offset_binary = VEC[v][48];
         step(VEC[v][47:36], VEC[v][35:24], 1'b0);
         check_pair(v[0] ? "R3" : "R2", VEC[v][23:12], VEC[v][11:0]);
      end
      cfg_offset_binary = 1'b0;

      // R9: stray completing word on entry
      cfg_one_port = 1'b1;
      step(12'h2AA, 12'h0, 1'b1);
      check_idle("R9", 1'b0);

      // R4, R6: I then Q
      step(12'h111, 12'h0, 1'b0);
      check_idle("R6", 1'b0);
      step(12'h222, 12'h0, 1'b1);
      check_pair("R4", 12'h111, 12'h222);

      // R5: QI ordering
      cfg_qi_order = 1'b1;
      step(12'h333, 12'h0, 1'b1);
      check_idle("R5", 1'b0);
      step(12'h444, 12'h0, 1'b0);
      check_pair("R5", 12'h444, 12'h333);

      // R4: select polarity inverted
      cfg_qi_order = 1'b0;
      cfg_sel_invert = 1'b1;
      step(12'h555, 12'h0, 1'b1);
      check_idle("R4", 1'b0);
      step(12'h666, 12'h0, 1'b0);
      check_pair("R4", 12'h555, 12'h666);

      // R3 in one-port mode
      cfg_sel_invert = 1'b0;
      cfg_offset_binary = 1'b1;
      step(12'h800, 12'h0, 1'b0);
      step(12'h000, 12'h0, 1'b1);
      check_pair("R3", 12'h000, 12'h800);
      cfg_offset_binary = 1'b0;

      // R7: repeated opening word
      step(12'h010, 12'h0, 1'b0);
      check_idle("R7", 1'b0);
      step(12'h020, 12'h0, 1'b0);
      check_idle("R7", 1'b1);
      step(12'h030, 12'h0, 1'b1);
      check_pair("R7", 12'h020, 12'h030);

      // R8: flag persists over clean traffic
      step(12'h040, 12'h0, 1'b0);
      step(12'h050, 12'h0, 1'b1);
      check_pair("R8", 12'h040, 12'h050);
      check(err_sticky == 1'b1, "R8", {31'd0, err_sticky}, 32'd1);

      // R8/R1: only reset clears it
      do_reset();

      // R7: repeated completing word
      step(12'h061, 12'h0, 1'b0);
      step(12'h062, 12'h0, 1'b1);
      check_pair("R7", 12'h061, 12'h062);
      step(12'h063, 12'h0, 1'b1);
      check_idle("R7", 1'b1);
      do_reset();

      // R10: leaving one-port drops held word
      cfg_one_port = 1'b1;
      step(12'h0AA, 12'h0, 1'b0);
      check_idle("R10", 1'b0);
      cfg_one_port = 1'b0;
      step(12'h123, 12'h321, 1'b0);
      check_pair("R10", 12'h123, 12'h321);
      cfg_one_port = 1'b1;
      step(12'h0BB, 12'h0, 1'b1);
      check_idle("R10", 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule